// File: doc/BRIEF.md
# ADC Output Data Formatter

This block takes each 14-bit converter result, with its overflow flag, and turns it into the word presented on the parallel output pins. The core result arrives as offset binary. Three controls shape it. A two's-complement option inverts the MSB. A scrambler XORs the upper bits with the LSB. A polarity option inverts every odd data bit, so that roughly half the pins rise while the other half fall.

A built-in pattern generator can replace the data word for board-level interface tests. It offers constant ones, constant zeros, a word that alternates between all ones and all zeros, and a checkerboard. The result is registered, so the pins change one clock after a sample strobe. A clock-out pin pulses in step with each new word. A pad drive-enable output lets the pad ring float the data, overflow and clock-out pins.

All controls are static configuration inputs. Register programming and power control belong to other blocks.

Top module: `adc_out_fmt`

## Requirements
- R1: The output word is {ovf_out, dout[13:0]} (overflow flag at bit 14). It loads on a clock edge where smp_vld is 1, is visible from the following cycle, and holds its value on every edge where smp_vld is 0.
- R2: With cfg_twos=1 and cfg_abp=0, bit 13 of the offset-binary input is inverted. All other bits are unchanged.
- R3: With cfg_rand=1, word bits 14 down to 1 (overflow included) are XORed with data bit 0, and bit 0 passes unchanged.
- R4: With cfg_abp=1, data bits 1, 3, 5, 7, 9, 11 and 13 are inverted and the overflow bit is not. cfg_twos has no effect while cfg_abp=1.
- R5: The options are independent and are applied in the order two's complement, then scrambler, then polarity inversion.
- R6: With cfg_tp_en=1, cfg_tp_sel selects the pattern. 0 gives 15'h7FFF. 1 gives 15'h0000. 2 gives 15'h7FFF then 15'h0000. 3 gives 15'h5555 then 15'h2AAA.
- R7: The two-phase patterns advance one phase per strobe and hold between strobes. Each time cfg_tp_en rises from 0, they restart at their first value.
- R8: While cfg_tp_en=1, the pattern ignores cfg_twos, cfg_rand and cfg_abp.
- R9: clk_out is 1 in the cycle after a strobe edge and 0 in the cycle after an edge without a strobe.
- R10: pad_drv equals cfg_oe in the same cycle. When it is 0, the pad ring floats dout, ovf_out and clk_out.
- R11: After reset, the output word and clk_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe from the converter core |
| smp_in | input | 14 | Offset-binary converter result |
| ovf_in | input | 1 | Overflow flag of the sample |
| cfg_twos | input | 1 | Two's-complement output format |
| cfg_rand | input | 1 | Scrambler enable |
| cfg_abp | input | 1 | Odd-bit polarity inversion enable |
| cfg_tp_en | input | 1 | Test pattern enable |
| cfg_tp_sel | input | 2 | Test pattern select |
| cfg_oe | input | 1 | Output drive enable |
| dout | output | 14 | Formatted data bits |
| ovf_out | output | 1 | Formatted overflow bit |
| clk_out | output | 1 | Output clock pulse aligned to the word |
| pad_drv | output | 1 | Drive enable for the output pad cells |

## Verification
The hardest state to reach is the phase of the two-phase patterns. It is hidden, it advances only on strobes, and it restarts only on a rising enable. The stimulus enables the checkerboard and alternating patterns in turn. It gives several strobes, inserts strobe-free cycles to show the phase holding, then drops and raises the enable to show the restart at the first value. The formatting options are set at the same time, so the pattern override is checked in the same pass.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    TP_ONES  = 2'd0,
    TP_ZEROS = 2'd1,
    TP_ALT   = 2'd2,
    TP_CHECK = 2'd3
  } tp_sel_e;
endpackage

// File: rtl/fmt_datapath.sv
module fmt_datapath #(
  parameter int DW = 14
) (
  input  logic [DW:0] raw_word,
  input  logic        cfg_twos,
  input  logic        cfg_rand,
  input  logic        cfg_abp,
  output logic [DW:0] fmt_word
);
  localparam int WW = DW + 1;

  // Inverts the data MSB (offset binary to two's complement)
  function automatic logic [WW-1:0] do_twos(input logic [WW-1:0] w);
    logic [WW-1:0] r;
    r = w;
    r[DW-1] = ~w[DW-1];
    return r;
  endfunction

  // XOR every bit above bit 0 with bit 0
  function automatic logic [WW-1:0] do_rand(input logic [WW-1:0] w);
    logic [WW-1:0] r;
    r = w;
    for (int i = 1; i < WW; i++) r[i] = w[i] ^ w[0];
    return r;
  endfunction

  // Odd data bits only; the overflow bit is left alone
  function automatic logic [WW-1:0] abp_mask();
    logic [WW-1:0] m;
    m = '0;
    for (int i = 1; i < DW; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  logic [WW-1:0] s_twos, s_rand;
  logic          twos_act;

  assign twos_act = cfg_twos & ~cfg_abp;
  assign s_twos   = twos_act ? do_twos(raw_word) : raw_word;
  assign s_rand   = cfg_rand ? do_rand(s_twos) : s_twos;
  assign fmt_word = cfg_abp ? (s_rand ^ abp_mask()) : s_rand;
endmodule

// File: rtl/fmt_pattern_gen.sv
module fmt_pattern_gen
  import adc_fmt_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic        tp_en,
  input  logic [1:0]  tp_sel,
  output logic        tp_phase,
  output logic [DW:0] tp_word
);
  localparam int WW = DW + 1;

  // Checkerboard first phase: MSB set, then alternating downward
  function automatic logic [WW-1:0] check_word();
    logic [WW-1:0] m;
    for (int i = 0; i < WW; i++) m[i] = ((WW - 1 - i) % 2) == 0;
    return m;
  endfunction

  function automatic logic [WW-1:0] pick(input logic [1:0] sel, input logic ph);
    case (tp_sel_e'(sel))
      TP_ONES:  return '1;
      TP_ZEROS: return '0;
      TP_ALT:   return ph ? '0 : '1;
      default:  return ph ? ~check_word() : check_word();
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tp_phase <= 1'b0;
    else if (!tp_en)  tp_phase <= 1'b0;
    else if (smp_vld) tp_phase <= ~tp_phase;
  end

  assign tp_word = pick(tp_sel, tp_phase);
endmodule

// File: rtl/fmt_out_stage.sv
module fmt_out_stage #(
  parameter int DW = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic [DW:0] nxt_word,
  output logic [DW:0] word_q,
  output logic        stb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= smp_vld;
      if (smp_vld) word_q <= nxt_word;
    end
  end
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_in,
  input  logic          ovf_in,
  input  logic          cfg_twos,
  input  logic          cfg_rand,
  input  logic          cfg_abp,
  input  logic          cfg_tp_en,
  input  logic [1:0]    cfg_tp_sel,
  input  logic          cfg_oe,
  output logic [DW-1:0] dout,
  output logic          ovf_out,
  output logic          clk_out,
  output logic          pad_drv
);
  logic [DW:0] raw_word, fmt_word, tp_word, nxt_word, word_q;
  logic        tp_phase, stb_q;

  assign raw_word = {ovf_in, smp_in};

  fmt_datapath #(.DW(DW)) u_dp (
    .raw_word (raw_word),
    .cfg_twos (cfg_twos),
    .cfg_rand (cfg_rand),
    .cfg_abp  (cfg_abp),
    .fmt_word (fmt_word)
  );

  fmt_pattern_gen #(.DW(DW)) u_tp (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .tp_en    (cfg_tp_en),
    .tp_sel   (cfg_tp_sel),
    .tp_phase (tp_phase),
    .tp_word  (tp_word)
  );

  assign nxt_word = cfg_tp_en ? tp_word : fmt_word;

  fmt_out_stage #(.DW(DW)) u_os (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .nxt_word (nxt_word),
    .word_q   (word_q),
    .stb_q    (stb_q)
  );

  assign dout    = word_q[DW-1:0];
  assign ovf_out = word_q[DW];
  assign clk_out = stb_q;
  assign pad_drv = cfg_oe;
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [DW-1:0] smp_in,
  input logic          cfg_twos,
  input logic          cfg_rand,
  input logic          cfg_abp,
  input logic          cfg_tp_en,
  input logic [DW-1:0] dout,
  input logic          ovf_out,
  input logic          clk_out,
  input logic          tp_phase,
  input logic [DW:0]   tp_word
);
  // R1
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable({ovf_out, dout}));

  // R2
  twos_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !cfg_tp_en && cfg_twos && !cfg_rand && !cfg_abp)
      |=> dout[DW-1] != $past(smp_in[DW-1]));

  // R8
  tp_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_tp_en) |=> {ovf_out, dout} == $past(tp_word));

  // R7
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_tp_en) |=> tp_phase != $past(tp_phase));

  // R7
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tp_en |=> !tp_phase);

  // R9
  clkout_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> clk_out);

  // R9
  clkout_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !clk_out);
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .smp_in    (smp_in),
  .cfg_twos  (cfg_twos),
  .cfg_rand  (cfg_rand),
  .cfg_abp   (cfg_abp),
  .cfg_tp_en (cfg_tp_en),
  .dout      (dout),
  .ovf_out   (ovf_out),
  .clk_out   (clk_out),
  .tp_phase  (tp_phase),
  .tp_word   (tp_word)
);

// File: tb/sim_adc_out_fmt.sv
module sim_adc_out_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [13:0] smp_in = '0;
  logic        ovf_in = 1'b0;
  logic        cfg_twos = 1'b0, cfg_rand = 1'b0, cfg_abp = 1'b0;
  logic        cfg_tp_en = 1'b0;
  logic [1:0]  cfg_tp_sel = 2'd0;
  logic        cfg_oe = 1'b1;
  logic [13:0] dout;
  logic        ovf_out, clk_out, pad_drv;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_out_fmt u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .ovf_in(ovf_in), .cfg_twos(cfg_twos), .cfg_rand(cfg_rand),
    .cfg_abp(cfg_abp), .cfg_tp_en(cfg_tp_en), .cfg_tp_sel(cfg_tp_sel),
    .cfg_oe(cfg_oe), .dout(dout), .ovf_out(ovf_out), .clk_out(clk_out),
    .pad_drv(pad_drv)
  );

  typedef struct packed {
    logic        ovf;
    logic [13:0] smp;
    logic        tw;
    logic        rn;
    logic        ab;
    logic [14:0] exp;
  } vec_t;

  // Expected words worked out by hand from R2..R5
  localparam vec_t VEC [11] = '{
    '{1'b0, 14'h0000, 1'b0, 1'b0, 1'b0, 15'h0000},
    '{1'b0, 14'h0000, 1'b1, 1'b0, 1'b0, 15'h2000},
    '{1'b0, 14'h1234, 1'b0, 1'b0, 1'b0, 15'h1234},
    '{1'b0, 14'h1234, 1'b1, 1'b0, 1'b0, 15'h3234},
    '{1'b0, 14'h1235, 1'b0, 1'b1, 1'b0, 15'h6DCB},
    '{1'b0, 14'h1234, 1'b0, 1'b1, 1'b0, 15'h1234},
    '{1'b0, 14'h0000, 1'b0, 1'b0, 1'b1, 15'h2AAA},
    '{1'b0, 14'h0000, 1'b1, 1'b0, 1'b1, 15'h2AAA},
    '{1'b1, 14'h0001, 1'b0, 1'b1, 1'b1, 15'h1555},
    '{1'b0, 14'h0001, 1'b1, 1'b1, 1'b0, 15'h5FFF},
    '{1'b1, 14'h3FFF, 1'b0, 1'b0, 1'b0, 15'h7FFF}
  };

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, give one strobe edge, sample at the next negedge
  task automatic strobe(input logic [14:0] w);
    @(negedge clk);
    ovf_in  = w[14];
    smp_in  = w[13:0];
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    // R10 pad enable follows cfg_oe
    check("R10", {14'd0, pad_drv}, 15'd1);
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11", {ovf_out, dout}, 15'h0000);
    check("R11", {14'd0, clk_out}, 15'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < 11; i++) begin
      cfg_twos = VEC[i].tw;
      cfg_rand = VEC[i].rn;
      cfg_abp  = VEC[i].ab;
      strobe({VEC[i].ovf, VEC[i].smp});
      check("R5", {ovf_out, dout}, VEC[i].exp);
    end
    // R9 clock-out after a strobe
    check("R9", {14'd0, clk_out}, 15'd1);

    // R1 hold without strobe
    cfg_twos = 1'b0; cfg_rand = 1'b0; cfg_abp = 1'b0;
    @(negedge clk);
    smp_in = 14'h0ABC; ovf_in = 1'b0;
    @(negedge clk);
    check("R1", {ovf_out, dout}, 15'h7FFF);
    check("R9", {14'd0, clk_out}, 15'd0);

    // R6 R8 patterns override every option
    cfg_twos = 1'b1; cfg_rand = 1'b1; cfg_abp = 1'b1;
    cfg_tp_en = 1'b1;
    cfg_tp_sel = 2'd0;
    strobe(15'h1235);
    check("R6", {ovf_out, dout}, 15'h7FFF);
    cfg_tp_en = 1'b0; @(negedge clk);
    cfg_tp_en = 1'b1; cfg_tp_sel = 2'd1;
    strobe(15'h1235);
    check("R8", {ovf_out, dout}, 15'h0000);

    // R7 alternating from first value
    cfg_tp_en = 1'b0; @(negedge clk);
    cfg_tp_en = 1'b1; cfg_tp_sel = 2'd2;
    strobe(15'h0001);
    check("R7", {ovf_out, dout}, 15'h7FFF);
    strobe(15'h0001);
    check("R7", {ovf_out, dout}, 15'h0000);
    idle();
    check("R7", {ovf_out, dout}, 15'h0000);
    strobe(15'h0001);
    check("R7", {ovf_out, dout}, 15'h7FFF);

    // R6 R7 checkerboard, then restart after re-enable
    cfg_tp_en = 1'b0; @(negedge clk);
    cfg_tp_en = 1'b1; cfg_tp_sel = 2'd3;
    strobe(15'h0000);
    check("R6", {ovf_out, dout}, 15'h5555);
    strobe(15'h0000);
    check("R6", {ovf_out, dout}, 15'h2AAA);
    strobe(15'h0000);
    check("R7", {ovf_out, dout}, 15'h5555);
    cfg_tp_en = 1'b0; @(negedge clk);
    cfg_tp_en = 1'b1;
    strobe(15'h0000);
    check("R7", {ovf_out, dout}, 15'h5555);

    // R4 back to data with polarity mode; overflow bit untouched
    cfg_tp_en = 1'b0; cfg_rand = 1'b0; cfg_twos = 1'b1; cfg_abp = 1'b1;
    strobe(15'h7FFF);
    check("R4", {ovf_out, dout}, 15'h5555);

    // R10 pad disable
    cfg_oe = 1'b0;
    #1;
    check("R10", {14'd0, pad_drv}, 15'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule